// File: doc/BRIEF.md
# Indirect Bus Access Command Bridge

This block lets a 64-bit configuration port reach an internal peripheral bus with 32-bit addresses, one transfer at a time. Software sees four 64-bit registers, selected by bits [4:3] of the access address. Storing a command word into the control register launches one bus transfer at once. There is no separate go bit. A scratch data register supplies the payload of a write. The outcome of each transfer is left in a status register that empties itself when read.

On the bus side the bridge issues a request with a valid/ready handshake and waits for a single response beat carrying read data and an error flag. Data moves as byte lanes, and lane 0 always carries the first byte. On a read, the first byte returned becomes the most significant byte of the 32-bit result. On a write, the most significant payload byte is sent first. A read that fails puts all ones in the data field of the status word instead of the returned data.

Top module: `cmdb_bridge`

## Requirements
- R1: The register is chosen by cfg_addr[4:3]: 0 control, 1 reset, 2 status, 3 data. A read of control or reset returns zero with cfg_rvalid high one cycle after the access.
- R2: A write to the data register stores cfg_wdata[63:32]. A read of it returns that value in bits [63:32] and zero in bits [31:0].
- R3: A status read returns the current status word and clears the register at the same clock edge. A second read then returns zero, unless a transfer completed in between.
- R4: A control write while idle raises bus_req_valid on the next cycle. The request fields are decoded from the control word as follows. Bit 48 set means a read, and bus_req_write is its inverse. Bits [59:56] are the byte count and drive bus_req_size. Bits [31:0] are the bus address and drive bus_req_addr. All other control bits are ignored.
- R5: A control word whose byte count exceeds 8 makes no request and leaves the status register unchanged.
- R6: A read that completes without error sets status to bit 11 (done) OR'd with the 32-bit read word shifted left by 26. The word is {lane0, lane1, lane2, lane3}, where lane k is bus_rsp_rdata[8k+7:8k].
- R7: A read that completes with bus_rsp_err set gives status 0x03FF_FFFF_FC00_0800, which is done plus 32 ones at bits [57:26].
- R8: A write carries the data register on bus_req_wdata with its bits [31:24] on lane 0 down to bits [7:0] on lane 3. Its completion sets status to exactly 0x800, whatever the error flag.
- R9: While bus_req_valid is high and bus_req_ready is low, the request stays valid and address, write flag, size and write data hold steady.
- R10: A control write that arrives while a transfer is outstanding is ignored. No second request is made and the ongoing transfer's status is kept.
- R11: While rst_n is low (synchronous), no request is driven, cfg_rvalid is low and the status register is zero. After reset the status and data registers read zero.
- R12: Writes to the reset and status registers change no state.
- R13: When a status read and a transfer completion fall on the same clock edge, the read returns the old status and the new completion value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration access strobe, one cycle per access |
| cfg_write | input | 1 | 1 = write access, 0 = read access |
| cfg_addr | input | CFG_AW | Byte address of the access; bits [4:3] select the register |
| cfg_wdata | input | 64 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read access |
| cfg_rdata | output | 64 | Read data |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_write | output | 1 | 1 = write transfer |
| bus_req_size | output | 4 | Transfer byte count |
| bus_req_addr | output | BUS_AW | Transfer address |
| bus_req_wdata | output | 8*WORD_BYTES | Write lanes, lane 0 in the low byte |
| bus_rsp_valid | input | 1 | Response beat for the accepted request |
| bus_rsp_err | input | 1 | Response reports an error |
| bus_rsp_rdata | input | 8*WORD_BYTES | Read lanes, lane 0 in the low byte |

## Verification
The bench uses the default parameters: a 5-bit configuration address, 32-bit bus addresses, four data lanes and an 8-byte size limit. With these values the size field's full 0..15 range is in play, so both sides of the 8/9 boundary are reached. The 32-bit word also spans status bits [57:26] completely. The bench's bus target model can stretch the ready and response delays, which exposes control writes that land mid-transfer. It can also pin the response to a fixed cycle, so that a status read coincides exactly with a completion.

// File: rtl/cmdb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the command bridge.
// Bit positions are given LSB-0; the command word layout is fixed by
// software, so these are package constants, not module parameters.
package cmdb_pkg;
    localparam int unsigned CFG_DW        = 64;
    localparam int unsigned SEL_LSB       = 3;   // register select cfg_addr[4:3]
    localparam int unsigned CTL_RD_POS    = 48;  // read flag
    localparam int unsigned CTL_SIZE_LSB  = 56;  // byte count [59:56]
    localparam int unsigned CTL_SIZE_W    = 4;
    localparam int unsigned STAT_DONE_POS = 11;  // completion flag
    localparam int unsigned STAT_WORD_LSB = 26;  // read word field [57:26]

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RESET  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_DATA   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_REQ  = 2'd1,
        XF_RSP  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/cmdb_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: splits a 64-bit control word into read flag, byte
// count and bus address, and flags byte counts above MAX_BYTES.
// Assumes BUS_AW <= 32 (address sits in the low word). Purely combinational.
module cmdb_cmd_decode
    import cmdb_pkg::*;
#(
    parameter int BUS_AW    = 32,
    parameter int MAX_BYTES = 8
) (
    input  logic [CFG_DW-1:0]     ctl_word,
    output logic                  cmd_read,
    output logic [CTL_SIZE_W-1:0] cmd_size,
    output logic [BUS_AW-1:0]     cmd_addr,
    output logic                  cmd_legal
);
    logic ctl_spare_unused;

    // Field extraction from the command word.
    assign cmd_read  = ctl_word[CTL_RD_POS];
    assign cmd_size  = ctl_word[CTL_SIZE_LSB +: CTL_SIZE_W];
    assign cmd_addr  = ctl_word[BUS_AW-1:0];
    assign cmd_legal = (32'(cmd_size) <= 32'(MAX_BYTES));

    // Remaining bits carry no meaning.
    assign ctl_spare_unused = ^ctl_word;
endmodule

// File: rtl/cmdb_lane_pack.sv
`timescale 1ns/1ps
// Lane packer: maps a register word onto bus byte lanes, most
// significant byte on lane 0, and rebuilds a word from returned lanes
// the same way. Combinational; WORD_BYTES lanes of 8 bits.
module cmdb_lane_pack #(
    parameter int WORD_BYTES = 4,
    localparam int WORD_W    = WORD_BYTES * 8
) (
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] tx_lanes,
    input  logic [WORD_W-1:0] rx_lanes,
    output logic [WORD_W-1:0] rx_word
);
    // One byte swap per lane, in both directions.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign tx_lanes[g*8 +: 8]                  = tx_word[(WORD_BYTES-1-g)*8 +: 8];
        assign rx_word[(WORD_BYTES-1-g)*8 +: 8]    = rx_lanes[g*8 +: 8];
    end
endmodule

// File: rtl/cmdb_xfer_fsm.sv
`timescale 1ns/1ps
// Transfer sequencer: latches one command, holds the request until it is
// accepted, then waits for one response beat. One transfer outstanding.
// Assumes the response arrives no earlier than the cycle after acceptance.
module cmdb_xfer_fsm
    import cmdb_pkg::*;
#(
    parameter int BUS_AW = 32,
    parameter int LANE_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_read,
    input  logic [CTL_SIZE_W-1:0] start_size,
    input  logic [BUS_AW-1:0]     start_addr,
    input  logic [LANE_W-1:0]     start_lanes,
    output logic                  bus_req_valid,
    input  logic                  bus_req_ready,
    output logic                  bus_req_write,
    output logic [CTL_SIZE_W-1:0] bus_req_size,
    output logic [BUS_AW-1:0]     bus_req_addr,
    output logic [LANE_W-1:0]     bus_req_wdata,
    input  logic                  bus_rsp_valid,
    output logic                  busy,
    output logic                  done,
    output logic                  done_read
);
    xfer_state_e           state_q;
    logic                  write_q;
    logic [CTL_SIZE_W-1:0] size_q;
    logic [BUS_AW-1:0]     addr_q;
    logic [LANE_W-1:0]     lanes_q;

    // State progression: idle -> request -> response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
        end else begin
            case (state_q)
                XF_IDLE: if (start)         state_q <= XF_REQ;
                XF_REQ:  if (bus_req_ready) state_q <= XF_RSP;
                XF_RSP:  if (bus_rsp_valid) state_q <= XF_IDLE;
                default:                    state_q <= XF_IDLE;
            endcase
        end
    end

    // Command capture, only when a new transfer is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            size_q  <= '0;
            addr_q  <= '0;
            lanes_q <= '0;
        end else if (start && state_q == XF_IDLE) begin
            write_q <= !start_read;
            size_q  <= start_size;
            addr_q  <= start_addr;
            lanes_q <= start_lanes;
        end
    end

    assign bus_req_valid = (state_q == XF_REQ);
    assign bus_req_write = write_q;
    assign bus_req_size  = size_q;
    assign bus_req_addr  = addr_q;
    assign bus_req_wdata = lanes_q;
    assign busy          = (state_q != XF_IDLE);
    assign done          = (state_q == XF_RSP) && bus_rsp_valid;
    assign done_read     = !write_q;
endmodule

// File: rtl/cmdb_bridge.sv
`timescale 1ns/1ps
// Command bridge top: four-register configuration window, command launch
// on control writes, status capture (clear on read) and data register.
// Assumes single-cycle configuration accesses of 8 bytes; cfg_addr[2:0]
// and bits above [4:3] are not decoded. Read data is registered.
module cmdb_bridge
    import cmdb_pkg::*;
#(
    parameter int CFG_AW     = 5,
    parameter int BUS_AW     = 32,
    parameter int WORD_BYTES = 4,
    parameter int MAX_BYTES  = 8,
    localparam int WORD_W    = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_valid,
    input  logic                  cfg_write,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    output logic                  cfg_rvalid,
    output logic [CFG_DW-1:0]     cfg_rdata,
    output logic                  bus_req_valid,
    input  logic                  bus_req_ready,
    output logic                  bus_req_write,
    output logic [CTL_SIZE_W-1:0] bus_req_size,
    output logic [BUS_AW-1:0]     bus_req_addr,
    output logic [WORD_W-1:0]     bus_req_wdata,
    input  logic                  bus_rsp_valid,
    input  logic                  bus_rsp_err,
    input  logic [WORD_W-1:0]     bus_rsp_rdata
);
    localparam logic [CFG_DW-1:0] DONE_MASK = CFG_DW'(1) << STAT_DONE_POS;

    logic [1:0]            sel_idx;
    reg_sel_e              sel;
    logic                  wr_ctl, wr_data, rd_any, rd_stat, start;
    logic                  cmd_read, cmd_legal;
    logic [CTL_SIZE_W-1:0] cmd_size;
    logic [BUS_AW-1:0]     cmd_addr;
    logic [WORD_W-1:0]     data_q, tx_lanes, rd_word, rd_field;
    logic [CFG_DW-1:0]     stat_q, stat_load, rd_mux;
    logic                  busy, done, done_read;
    logic                  cfg_spare_unused;

    // Register select and access strobes.
    assign sel_idx = cfg_addr[SEL_LSB +: 2];
    assign sel     = reg_sel_e'(sel_idx);
    assign wr_ctl  = cfg_valid && cfg_write && (sel == SEL_CTRL);
    assign wr_data = cfg_valid && cfg_write && (sel == SEL_DATA);
    assign rd_any  = cfg_valid && !cfg_write;
    assign rd_stat = rd_any && (sel == SEL_STATUS);
    assign start   = wr_ctl && cmd_legal && !busy;
    assign cfg_spare_unused = ^cfg_addr;

    cmdb_cmd_decode #(
        .BUS_AW    (BUS_AW),
        .MAX_BYTES (MAX_BYTES)
    ) u_decode (
        .ctl_word  (cfg_wdata),
        .cmd_read  (cmd_read),
        .cmd_size  (cmd_size),
        .cmd_addr  (cmd_addr),
        .cmd_legal (cmd_legal)
    );

    cmdb_lane_pack #(
        .WORD_BYTES (WORD_BYTES)
    ) u_pack (
        .tx_word  (data_q),
        .tx_lanes (tx_lanes),
        .rx_lanes (bus_rsp_rdata),
        .rx_word  (rd_word)
    );

    cmdb_xfer_fsm #(
        .BUS_AW (BUS_AW),
        .LANE_W (WORD_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_read    (cmd_read),
        .start_size    (cmd_size),
        .start_addr    (cmd_addr),
        .start_lanes   (tx_lanes),
        .bus_req_valid (bus_req_valid),
        .bus_req_ready (bus_req_ready),
        .bus_req_write (bus_req_write),
        .bus_req_size  (bus_req_size),
        .bus_req_addr  (bus_req_addr),
        .bus_req_wdata (bus_req_wdata),
        .bus_rsp_valid (bus_rsp_valid),
        .busy          (busy),
        .done          (done),
        .done_read     (done_read)
    );

    // Data register: upper half of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= cfg_wdata[CFG_DW-1 -: WORD_W];
    end

    // Completion word: done flag plus read word or all-ones on error.
    always_comb begin
        rd_field  = bus_rsp_err ? '1 : rd_word;
        stat_load = DONE_MASK;
        if (done_read) stat_load = stat_load | (CFG_DW'(rd_field) << STAT_WORD_LSB);
    end

    // Status register: completion wins over the clear of a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (done)    stat_q <= stat_load;
        else if (rd_stat) stat_q <= '0;
    end

    // Read multiplexer; control and reset read as zero.
    always_comb begin
        case (sel)
            SEL_STATUS: rd_mux = stat_q;
            SEL_DATA:   rd_mux = {data_q, {(CFG_DW-WORD_W){1'b0}}};
            default:    rd_mux = '0;
        endcase
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= rd_any;
            cfg_rdata  <= rd_any ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/cmdb_chk.sv
`timescale 1ns/1ps
// Checker for the command bridge: protocol and status properties,
// bound to every cmdb_bridge instance. Tracks the outstanding transfer
// itself from the bus handshake.
module cmdb_chk
    import cmdb_pkg::*;
#(
    parameter int BUS_AW    = 32,
    parameter int WORD_W    = 32,
    parameter int MAX_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_valid,
    input logic                  cfg_write,
    input logic [1:0]            cfg_sel,
    input logic [CTL_SIZE_W-1:0] ctl_size,
    input logic                  cfg_rvalid,
    input logic [CFG_DW-1:0]     cfg_rdata,
    input logic                  bus_req_valid,
    input logic                  bus_req_ready,
    input logic                  bus_req_write,
    input logic [CTL_SIZE_W-1:0] bus_req_size,
    input logic [BUS_AW-1:0]     bus_req_addr,
    input logic [WORD_W-1:0]     bus_req_wdata,
    input logic                  bus_rsp_valid,
    input logic                  bus_rsp_err,
    input logic [CFG_DW-1:0]     status_q
);
    localparam logic [CFG_DW-1:0] DONE_W = CFG_DW'(1) << STAT_DONE_POS;
    localparam logic [CFG_DW-1:0] FAIL_W = DONE_W | (CFG_DW'({WORD_W{1'b1}}) << STAT_WORD_LSB);

    logic pend, pend_rd;

    // Outstanding-transfer tracker seen from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_rd <= 1'b0;
        end else if (bus_req_valid && bus_req_ready) begin
            pend    <= 1'b1;
            pend_rd <= !bus_req_write;
        end else if (bus_rsp_valid) begin
            pend    <= 1'b0;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
        && $stable(bus_req_write) && $stable(bus_req_size) && $stable(bus_req_wdata));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !bus_req_valid && !cfg_rvalid && status_q == '0);

    // R5
    oversize_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_write && cfg_sel == 2'd0 && 32'(ctl_size) > 32'(MAX_BYTES)
        && !bus_req_valid && !pend |=> !bus_req_valid && $stable(status_q));

    // R7
    read_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && pend_rd && bus_rsp_valid && bus_rsp_err |=> status_q == FAIL_W);

    // R8
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !pend_rd && bus_rsp_valid |=> status_q == DONE_W);

    // R1
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_write && !cfg_sel[1] |=> cfg_rvalid && cfg_rdata == '0);

    // R3
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_write && cfg_sel == 2'd2 && !(pend && bus_rsp_valid)
        |=> status_q == '0);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_write && cfg_sel == 2'd0 && pend && !bus_rsp_valid
        |=> !bus_req_valid);
endmodule

bind cmdb_bridge cmdb_chk #(
    .BUS_AW    (BUS_AW),
    .WORD_W    (WORD_W),
    .MAX_BYTES (MAX_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_valid     (cfg_valid),
    .cfg_write     (cfg_write),
    .cfg_sel       (sel_idx),
    .ctl_size      (cmd_size),
    .cfg_rvalid    (cfg_rvalid),
    .cfg_rdata     (cfg_rdata),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_write (bus_req_write),
    .bus_req_size  (bus_req_size),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_err   (bus_rsp_err),
    .status_q      (stat_q)
);

// File: tb/cmdb_bridge_bench.sv
`timescale 1ns/1ps
// Bench: bus target model with random delays, directed corner cases and a
// seeded random command stream, all checked against bench-side models.
module cmdb_bridge_bench;
    localparam int CFG_AW = 5, BUS_AW = 32, WORD_BYTES = 4, MAX_BYTES = 8;
    localparam logic [63:0] DONE = 64'h800;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [63:0] cfg_rdata;
    logic        bus_req_valid, bus_req_write;
    logic        bus_req_ready = 1'b0;
    logic [3:0]  bus_req_size;
    logic [31:0] bus_req_addr, bus_req_wdata;
    logic        bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;

    cmdb_bridge #(
        .CFG_AW(CFG_AW), .BUS_AW(BUS_AW), .WORD_BYTES(WORD_BYTES), .MAX_BYTES(MAX_BYTES)
    ) u_cmdb_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
        .cfg_rdata(cfg_rdata), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_size(bus_req_size), .bus_req_addr(bus_req_addr),
        .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    int checks = 0, fails = 0, cycles = 0;
    int req_count = 0, rsp_count = 0;
    bit slow_mode = 0, fixed_mode = 0;
    int err_mode = 0;   // 0 random, 1 force error, 2 no error
    logic        exp_rd = 1'b0;
    logic [3:0]  exp_size = '0;
    logic [31:0] exp_addr = '0, exp_data = '0;
    logic [63:0] exp_status = '0;
    logic        last_rd = 1'b0, last_err = 1'b0;
    logic [31:0] last_word = '0;
    event        rsp_ev;

    function automatic logic [31:0] swap4(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [63:0] status_after(input logic rd, input logic err, input logic [31:0] w);
        if (!rd) return DONE;
        if (err) return DONE | (64'hFFFF_FFFF << 26);
        return DONE | (64'(w) << 26);
    endfunction

    function automatic logic [63:0] ctl_word(input logic rd, input logic [3:0] sz, input logic [31:0] a);
        logic [63:0] junk;
        junk = {$urandom, $urandom} & ~((64'hF << 56) | (64'h1 << 48) | 64'hFFFF_FFFF);
        return junk | (64'(sz) << 56) | (64'(rd) << 48) | 64'(a);
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                summary_end();
            end
        end
    end

    // Bus target model.
    initial begin : target
        int d;
        logic [31:0] w;
        forever begin
            @(negedge clk);
            if (bus_req_valid) begin
                d = fixed_mode ? 0 : int'($urandom_range(0, 2));
                repeat (d) @(negedge clk);
                check("R9", "valid held", 64'(bus_req_valid), 64'd1);
                check("R4", "write flag", 64'(bus_req_write), 64'(!exp_rd));
                check("R4", "size", 64'(bus_req_size), 64'(exp_size));
                check("R4", "address", 64'(bus_req_addr), 64'(exp_addr));
                if (!exp_rd) check("R8", "write lanes", 64'(bus_req_wdata), 64'(swap4(exp_data)));
                last_rd = !bus_req_write;
                req_count++;
                bus_req_ready = 1'b1;
                @(negedge clk);
                bus_req_ready = 1'b0;
                d = slow_mode ? 8 : (fixed_mode ? 2 : int'($urandom_range(0, 3)));
                repeat (d) @(negedge clk);
                w = fixed_mode ? 32'hC35A_A53C : $urandom;
                last_word = w;
                last_err  = (err_mode == 1) ? 1'b1 : (err_mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
                bus_rsp_rdata = swap4(w);
                bus_rsp_err   = last_err;
                -> rsp_ev;
                bus_rsp_valid = 1'b1;
                @(negedge clk);
                bus_rsp_valid = 1'b0;
                rsp_count++;
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] idx, input logic [63:0] v);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = {idx, 3'($urandom_range(0, 7))}; cfg_wdata = v;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] idx, output logic [63:0] v);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = {idx, 3'b000};
        @(negedge clk);
        cfg_valid = 1'b0;
        check("R1", "rvalid", 64'(cfg_rvalid), 64'd1);
        v = cfg_rdata;
    endtask

    task automatic wait_rsp(input int n0);
        int guard = 0;
        while (rsp_count == n0 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 300) check("R4", "response seen", 64'd0, 64'd1);
    endtask

    task automatic run_cmd(input logic rd, input logic [3:0] sz, input logic [31:0] a, input bit rd_stat);
        int n0, r0;
        logic [63:0] v;
        exp_rd = rd; exp_size = sz; exp_addr = a;
        n0 = rsp_count; r0 = req_count;
        cfg_wr(2'd0, ctl_word(rd, sz, a));
        if (sz > 4'(MAX_BYTES)) begin
            repeat (6) @(negedge clk);
            check("R5", "no request", 64'(req_count), 64'(r0));
        end else begin
            wait_rsp(n0);
            exp_status = status_after(last_rd, last_err, last_word);
        end
        if (rd_stat) begin
            cfg_rd(2'd2, v);
            check(rd ? (last_err ? "R7" : "R6") : "R8", "status", v, exp_status);
            exp_status = '0;
        end
    endtask

    initial begin : main
        logic [63:0] v, s1;
        int n0, r0;
        void'($urandom(32'd1234));
        // R11 reset state
        repeat (4) @(negedge clk);
        check("R11", "no request in reset", 64'(bus_req_valid), 64'd0);
        check("R11", "no rvalid in reset", 64'(cfg_rvalid), 64'd0);
        rst_n = 1'b1;
        cfg_rd(2'd2, v); check("R11", "status after reset", v, 64'd0);
        cfg_rd(2'd3, v); check("R11", "data after reset", v, 64'd0);

        // R2 data register
        v = {$urandom, $urandom};
        cfg_wr(2'd3, v); exp_data = v[63:32];
        cfg_rd(2'd3, v); check("R2", "data readback", v, {exp_data, 32'd0});

        // R1 control and reset read zero
        cfg_rd(2'd0, v); check("R1", "control reads zero", v, 64'd0);
        cfg_rd(2'd1, v); check("R1", "reset reads zero", v, 64'd0);

        // R6 / R7 / R8 directed
        err_mode = 2; run_cmd(1'b1, 4'd4, 32'hD001_0060, 1'b1);
        err_mode = 1; run_cmd(1'b1, 4'd1, 32'h1234_5678, 1'b1);
        err_mode = 1; run_cmd(1'b0, 4'd4, 32'hC001_2034, 1'b1);
        err_mode = 2; run_cmd(1'b0, 4'd8, 32'hFFFF_FFFC, 1'b1);
        // R3 second read empty
        cfg_rd(2'd2, v); check("R3", "second status read", v, 64'd0);

        // R5 boundary: size 9 and 15 dropped, status kept
        err_mode = 2; run_cmd(1'b1, 4'd2, 32'h0000_00AA, 1'b0);
        run_cmd(1'b1, 4'd9, 32'h0000_0BAD, 1'b0);
        run_cmd(1'b0, 4'd15, 32'h0000_0BAD, 1'b1);

        // R12 writes to reset and status ignored
        run_cmd(1'b1, 4'd4, 32'h0000_0100, 1'b0);
        cfg_wr(2'd1, {$urandom, $urandom});
        cfg_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R12", "no request from reset/status write", 64'(bus_req_valid), 64'd0);
        cfg_rd(2'd2, v); check("R12", "status kept", v, exp_status); exp_status = '0;
        cfg_rd(2'd3, v); check("R12", "data kept", v, {exp_data, 32'd0});

        // R10 control write while busy
        slow_mode = 1; err_mode = 2;
        exp_rd = 1'b1; exp_size = 4'd4; exp_addr = 32'hE000_0010;
        n0 = rsp_count; r0 = req_count;
        cfg_wr(2'd0, ctl_word(1'b1, 4'd4, 32'hE000_0010));
        repeat (2) @(negedge clk);
        cfg_wr(2'd0, ctl_word(1'b0, 4'd2, 32'h0BAD_0BAD));
        wait_rsp(n0);
        repeat (10) @(negedge clk);
        check("R10", "single request", 64'(req_count), 64'(r0 + 1));
        cfg_rd(2'd2, v); check("R10", "status of first command", v, status_after(1'b1, 1'b0, last_word));
        slow_mode = 0;

        // R13 status read on the completion edge
        fixed_mode = 1; err_mode = 2;
        run_cmd(1'b1, 4'd4, 32'hD001_0000, 1'b0);
        s1 = exp_status;
        exp_rd = 1'b0; exp_size = 4'd4; exp_addr = 32'hD001_0004;
        n0 = rsp_count;
        cfg_wr(2'd0, ctl_word(1'b0, 4'd4, 32'hD001_0004));
        @rsp_ev;
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = 5'b10000;
        @(negedge clk);
        cfg_valid = 1'b0;
        check("R13", "read returns old status", cfg_rdata, s1);
        wait_rsp(n0);
        cfg_rd(2'd2, v); check("R13", "completion kept", v, DONE);
        exp_status = '0;
        fixed_mode = 0;

        // Random stream
        err_mode = 0;
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                v = {$urandom, $urandom};
                cfg_wr(2'd3, v); exp_data = v[63:32];
            end
            run_cmd(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), $urandom,
                    $urandom_range(0, 3) != 0);
        end
        cfg_rd(2'd2, v); check("R3", "final status", v, exp_status);

        summary_end();
    end
endmodule